// File: doc/BRIEF.md
# Barrel Interleaved Thread Sequencer

This block sequences a fine-grained multithreaded pipeline in which every clock cycle issues from a different hardware thread. It keeps one program counter per thread, steps an issue slot through the threads in fixed round-robin order, and gives each issued instruction a thread tag. The tag travels with the instruction down a fixed-depth pipeline. At the read stage the tag picks the register bank to read. At the final stage it picks the bank to write and the program-counter slot to update.

The block is sized so that the thread count is at least the pipeline depth. A thread's next instruction therefore issues no earlier than the cycle after its previous instruction has written back, and no forwarding or interlock is needed. Decode, execution and memory sit outside this block. The only feedback it takes is a redirect flag and target at write-back. Threads can be masked off. A masked slot still takes its cycle and issues a bubble, so the rotation timing never changes.

Top module: `barrel_thread_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the issue slot is thread 0, no stage holds a valid instruction, and thread i holds PC = RESET_BASE + i*RESET_STRIDE. Each thread issues its reset PC on its first slot.
- R2: `issue_tid` advances by one every cycle and wraps from N_THREADS-1 to 0, whatever the enable mask holds.
- R3: When `thread_en[issue_tid]` is 0 the slot issues a bubble (`issue_valid`=0), the rotation goes on, and that thread's PC stays unchanged.
- R4: `rd_valid`/`rd_tid`/`rd_pc` equal the issue values of one cycle earlier. `wb_valid`/`wb_tid`/`wb_pc` equal the issue values of DEPTH-1 cycles earlier.
- R5: A valid write-back with `wb_redirect`=0 sets the PC of thread `wb_tid` to `wb_pc`+PC_STEP and leaves every other thread's PC unchanged. `wb_target` is ignored.
- R6: A valid write-back with `wb_redirect`=1 sets the PC of thread `wb_tid` to `wb_target`.
- R7: With no redirects, each enabled thread's issued PC grows by PC_STEP from one of its slots to the next, N_THREADS cycles later.
- R8: A bubble in the final stage changes no PC, even when `wb_redirect` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thread_en | input | N_THREADS | Per-thread enable; bit i enables thread i |
| issue_valid | output | 1 | Current slot issues a real instruction |
| issue_tid | output | $clog2(N_THREADS) | Thread owning the current slot |
| issue_pc | output | PC_W | PC of that thread |
| rd_valid | output | 1 | Read stage holds a valid instruction |
| rd_tid | output | $clog2(N_THREADS) | Register bank select at read |
| rd_pc | output | PC_W | PC of the read-stage instruction |
| wb_valid | output | 1 | Final stage holds a valid instruction |
| wb_tid | output | $clog2(N_THREADS) | Register bank and PC slot select at write-back |
| wb_pc | output | PC_W | PC of the write-back instruction |
| wb_redirect | input | 1 | Final-stage instruction redirects its thread |
| wb_target | input | PC_W | Redirect target |

## Verification
The checker module checks on every cycle that the slot steps by exactly one, that the read-stage tag matches the previous issue, and that the write-back tag lines up arithmetically with the issue slot DEPTH-1 cycles back. It also checks that each valid write-back lands its new PC in the tagged thread's slot and that a final-stage bubble leaves every PC unchanged. Only the bench scenarios can show the longer-range behaviour. They check that each thread's stream advances one step per full rotation, that masked threads hold their PC across many rotations, that redirects issued under changing masks land on the right thread, and that a redirect raised during a bubble is ignored.

// File: rtl/bts_pkg.sv
package bts_pkg;
   // Kind of program-counter update applied at write-back
   typedef enum logic [0:0] {
      PCU_STEP = 1'b0,
      PCU_JUMP = 1'b1
   } pc_update_e;
endpackage

// File: rtl/bts_rotor.sv
module bts_rotor #(
   parameter int unsigned N_THREADS = 4,
   parameter int unsigned TID_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [TID_W-1:0] slot
);
   localparam bit IS_POW2 = ((N_THREADS & (N_THREADS - 1)) == 0);
   localparam logic [TID_W-1:0] LAST = TID_W'(N_THREADS - 1);

   generate
      if (IS_POW2) begin : g_natural_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot <= '0;
            else        slot <= slot + 1'b1;
         end
      end else begin : g_compare_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            slot <= '0;
            else if (slot == LAST) slot <= '0;
            else                   slot <= slot + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/bts_pc_file.sv
module bts_pc_file
   import bts_pkg::*;
#(
   parameter int unsigned     N_THREADS    = 4,
   parameter int unsigned     TID_W        = 2,
   parameter int unsigned     PC_W         = 16,
   parameter int unsigned     PC_STEP      = 4,
   parameter logic [PC_W-1:0] RESET_BASE   = 'h0100,
   parameter logic [PC_W-1:0] RESET_STRIDE = 'h0400
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [TID_W-1:0]          sel_tid,
   output logic [PC_W-1:0]           sel_pc,
   input  logic                      upd_en,
   input  logic [TID_W-1:0]          upd_tid,
   input  pc_update_e                upd_kind,
   input  logic [PC_W-1:0]           upd_base,
   input  logic [PC_W-1:0]           upd_target,
   output logic [N_THREADS*PC_W-1:0] pc_all
);
   logic [PC_W-1:0] upd_value;

   always_comb begin
      if (upd_kind == PCU_JUMP) upd_value = upd_target;
      else                      upd_value = upd_base + PC_W'(PC_STEP);
   end

   generate
      for (genvar t = 0; t < N_THREADS; t++) begin : g_ctx
         localparam logic [PC_W-1:0] VEC = RESET_BASE + PC_W'(t) * RESET_STRIDE;
         logic [PC_W-1:0] pc_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pc_r <= VEC;
            else if (upd_en && (upd_tid == TID_W'(t)))
               pc_r <= upd_value;
         end
         assign pc_all[t*PC_W +: PC_W] = pc_r;
      end
   endgenerate

   assign sel_pc = pc_all[sel_tid*PC_W +: PC_W];
endmodule

// File: rtl/bts_tag_pipe.sv
module bts_tag_pipe #(
   parameter int unsigned STAGES = 3,
   parameter int unsigned TID_W  = 2,
   parameter int unsigned PC_W   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [TID_W-1:0] in_tid,
   input  logic [PC_W-1:0]  in_pc,
   output logic             first_valid,
   output logic [TID_W-1:0] first_tid,
   output logic [PC_W-1:0]  first_pc,
   output logic             last_valid,
   output logic [TID_W-1:0] last_tid,
   output logic [PC_W-1:0]  last_pc
);
   typedef struct packed {
      logic             vld;
      logic [TID_W-1:0] tid;
      logic [PC_W-1:0]  pc;
   } tag_t;

   tag_t stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= '{vld: in_valid, tid: in_tid, pc: in_pc};
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign first_valid = stg[0].vld;
   assign first_tid   = stg[0].tid;
   assign first_pc    = stg[0].pc;
   assign last_valid  = stg[STAGES-1].vld;
   assign last_tid    = stg[STAGES-1].tid;
   assign last_pc     = stg[STAGES-1].pc;
endmodule

// File: rtl/barrel_thread_seq.sv
module barrel_thread_seq
   import bts_pkg::*;
#(
   parameter int unsigned     N_THREADS    = 4,
   parameter int unsigned     DEPTH        = 4,
   parameter int unsigned     PC_W         = 16,
   parameter int unsigned     PC_STEP      = 4,
   parameter logic [PC_W-1:0] RESET_BASE   = 'h0100,
   parameter logic [PC_W-1:0] RESET_STRIDE = 'h0400,
   localparam int unsigned    TID_W        = $clog2(N_THREADS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_THREADS-1:0] thread_en,
   output logic                 issue_valid,
   output logic [TID_W-1:0]     issue_tid,
   output logic [PC_W-1:0]      issue_pc,
   output logic                 rd_valid,
   output logic [TID_W-1:0]     rd_tid,
   output logic [PC_W-1:0]      rd_pc,
   output logic                 wb_valid,
   output logic [TID_W-1:0]     wb_tid,
   output logic [PC_W-1:0]      wb_pc,
   input  logic                 wb_redirect,
   input  logic [PC_W-1:0]      wb_target
);
   localparam int unsigned REG_STAGES = DEPTH - 1;

   generate
      if (N_THREADS < 2) begin : g_bad_threads
         $error("barrel_thread_seq: N_THREADS must be at least 2");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("barrel_thread_seq: DEPTH must be at least 2");
      end
      if (N_THREADS < DEPTH) begin : g_bad_ratio
         $error("barrel_thread_seq: N_THREADS must not be below DEPTH");
      end
      if (PC_STEP == 0) begin : g_bad_step
         $error("barrel_thread_seq: PC_STEP must be non-zero");
      end
   endgenerate

   logic [N_THREADS*PC_W-1:0] pc_all;
   pc_update_e                upd_kind;

   bts_rotor #(
      .N_THREADS(N_THREADS),
      .TID_W    (TID_W)
   ) i_rotor (
      .clk  (clk),
      .rst_n(rst_n),
      .slot (issue_tid)
   );

   assign issue_valid = thread_en[issue_tid];
   assign upd_kind    = wb_redirect ? PCU_JUMP : PCU_STEP;

   bts_pc_file #(
      .N_THREADS   (N_THREADS),
      .TID_W       (TID_W),
      .PC_W        (PC_W),
      .PC_STEP     (PC_STEP),
      .RESET_BASE  (RESET_BASE),
      .RESET_STRIDE(RESET_STRIDE)
   ) i_pc_file (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_tid   (issue_tid),
      .sel_pc    (issue_pc),
      .upd_en    (wb_valid),
      .upd_tid   (wb_tid),
      .upd_kind  (upd_kind),
      .upd_base  (wb_pc),
      .upd_target(wb_target),
      .pc_all    (pc_all)
   );

   bts_tag_pipe #(
      .STAGES(REG_STAGES),
      .TID_W (TID_W),
      .PC_W  (PC_W)
   ) i_tag_pipe (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (issue_valid),
      .in_tid     (issue_tid),
      .in_pc      (issue_pc),
      .first_valid(rd_valid),
      .first_tid  (rd_tid),
      .first_pc   (rd_pc),
      .last_valid (wb_valid),
      .last_tid   (wb_tid),
      .last_pc    (wb_pc)
   );
endmodule

// File: rtl/bts_checker.sv
module bts_checker #(
   parameter int unsigned N_THREADS = 4,
   parameter int unsigned DEPTH     = 4,
   parameter int unsigned PC_W      = 16,
   parameter int unsigned PC_STEP   = 4,
   parameter int unsigned TID_W     = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      issue_valid,
   input logic [TID_W-1:0]          issue_tid,
   input logic                      rd_valid,
   input logic [TID_W-1:0]          rd_tid,
   input logic                      wb_valid,
   input logic [TID_W-1:0]          wb_tid,
   input logic [PC_W-1:0]           wb_pc,
   input logic                      wb_redirect,
   input logic [PC_W-1:0]           wb_target,
   input logic [N_THREADS*PC_W-1:0] pc_all
);
   logic             armed;
   logic             exp_v;
   logic [TID_W-1:0] exp_t;
   logic [PC_W-1:0]  exp_pc;
   logic [PC_W-1:0]  pc_at_exp;
   logic [TID_W-1:0] next_tid;
   logic [TID_W-1:0] align_tid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed  <= 1'b0;
         exp_v  <= 1'b0;
         exp_t  <= '0;
         exp_pc <= '0;
      end else begin
         armed  <= 1'b1;
         exp_v  <= wb_valid;
         exp_t  <= wb_tid;
         exp_pc <= wb_redirect ? wb_target : wb_pc + PC_W'(PC_STEP);
      end
   end

   assign pc_at_exp = pc_all[exp_t*PC_W +: PC_W];
   assign next_tid  = (int'(issue_tid) == N_THREADS - 1) ? '0 : issue_tid + 1'b1;
   assign align_tid = TID_W'((int'(issue_tid) + N_THREADS - (DEPTH - 1)) % N_THREADS);

   AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> issue_tid == $past(next_tid)); // R2
   AST_RD_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (rd_valid == $past(issue_valid)) && (rd_tid == $past(issue_tid))); // R4
   AST_WB_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> wb_tid == align_tid); // R4
   AST_WB_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      exp_v |-> pc_at_exp == exp_pc); // R6
   AST_BUBBLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !wb_valid) |=> $stable(pc_all)); // R8
endmodule

bind barrel_thread_seq bts_checker #(
   .N_THREADS(N_THREADS),
   .DEPTH    (DEPTH),
   .PC_W     (PC_W),
   .PC_STEP  (PC_STEP),
   .TID_W    (TID_W)
) i_bts_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .issue_valid(issue_valid),
   .issue_tid  (issue_tid),
   .rd_valid   (rd_valid),
   .rd_tid     (rd_tid),
   .wb_valid   (wb_valid),
   .wb_tid     (wb_tid),
   .wb_pc      (wb_pc),
   .wb_redirect(wb_redirect),
   .wb_target  (wb_target),
   .pc_all     (pc_all)
);

// File: tb/test_barrel_thread_seq.sv
module test_barrel_thread_seq;
   localparam int N     = 4;
   localparam int DEPTH = 4;
   localparam int PC_W  = 16;
   localparam int STEP  = 4;
   localparam logic [15:0] BASE   = 16'h0100;
   localparam logic [15:0] STRIDE = 16'h0400;
   localparam int NCYC  = 140;
   localparam int WB    = DEPTH - 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    thread_en = '1;
   logic            issue_valid, rd_valid, wb_valid;
   logic [1:0]      issue_tid, rd_tid, wb_tid;
   logic [PC_W-1:0] issue_pc, rd_pc, wb_pc;
   logic            wb_redirect = 1'b0;
   logic [PC_W-1:0] wb_target = '0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   barrel_thread_seq #(
      .N_THREADS(N), .DEPTH(DEPTH), .PC_W(PC_W), .PC_STEP(STEP),
      .RESET_BASE(BASE), .RESET_STRIDE(STRIDE)
   ) i_barrel_thread_seq (
      .clk(clk), .rst_n(rst_n), .thread_en(thread_en),
      .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_pc(issue_pc),
      .rd_valid(rd_valid), .rd_tid(rd_tid), .rd_pc(rd_pc),
      .wb_valid(wb_valid), .wb_tid(wb_tid), .wb_pc(wb_pc),
      .wb_redirect(wb_redirect), .wb_target(wb_target)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic [N-1:0] mask_for(int c);
      if (c < 40)  return 4'b1111;
      if (c < 64)  return 4'b1010;
      if (c < 100) return 4'b1111;
      if (c < 116) return 4'b0001;
      return 4'b1111;
   endfunction

   // expected model built from the requirements
   logic [PC_W-1:0] e_pc [N];
   string           e_tag [N];
   logic            h_v [DEPTH-1];
   logic [1:0]      h_t [DEPTH-1];
   logic [PC_W-1:0] h_p [DEPTH-1];
   int              e_ptr;

   initial begin
      for (int t = 0; t < N; t++) begin
         e_pc[t]  = BASE + PC_W'(t) * STRIDE;
         e_tag[t] = "R1";
      end
      for (int s = 0; s < DEPTH - 1; s++) begin
         h_v[s] = 1'b0; h_t[s] = '0; h_p[s] = '0;
      end
      e_ptr = 0;

      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      chk("R1", "reset issue_tid", 32'(issue_tid), 0);
      chk("R1", "reset issue_pc", 32'(issue_pc), 32'(BASE));
      chk("R1", "reset rd_valid", 32'(rd_valid), 0);
      chk("R1", "reset wb_valid", 32'(wb_valid), 0);
      rst_n = 1'b1;

      for (int c = 0; c < NCYC; c++) begin
         logic            en_now, redir;
         logic [PC_W-1:0] tgt, ipc;
         thread_en = mask_for(c);
         #1;
         en_now = thread_en[e_ptr];
         ipc    = e_pc[e_ptr];
         chk("R2", "issue_tid", 32'(issue_tid), 32'(e_ptr));
         chk("R3", "issue_valid", 32'(issue_valid), 32'(en_now));
         chk(en_now ? e_tag[e_ptr] : "R3", "issue_pc", 32'(issue_pc), 32'(ipc));
         chk("R4", "rd valid/tid", 32'({rd_valid, rd_tid}), 32'({h_v[0], h_t[0]}));
         if (h_v[0]) chk("R4", "rd_pc", 32'(rd_pc), 32'(h_p[0]));
         chk("R4", "wb valid/tid", 32'({wb_valid, wb_tid}), 32'({h_v[WB], h_t[WB]}));
         if (h_v[WB]) chk("R4", "wb_pc", 32'(wb_pc), 32'(h_p[WB]));

         // choose write-back feedback for this cycle
         redir = 1'b0;
         tgt   = PC_W'(c * 'h111);
         if (c >= 40 && c < 64) begin
            redir = !h_v[WB];
            tgt   = 16'hDEAD;
         end else if (c >= 64 && c < 100) begin
            redir = h_v[WB] && (c % 3 == 0);
            tgt   = 16'h2000 + PC_W'(c * 8);
         end
         wb_redirect = redir;
         wb_target   = tgt;

         // model: write-back effect, then pipeline shift, then slot advance
         if (h_v[WB]) begin
            if (redir) begin
               e_pc[h_t[WB]]  = tgt;
               e_tag[h_t[WB]] = "R6";
            end else begin
               e_pc[h_t[WB]]  = h_p[WB] + PC_W'(STEP);
               e_tag[h_t[WB]] = (c >= 64 && c < 100) ? "R5" : "R7";
            end
         end else if (redir) begin
            e_tag[h_t[WB]] = "R8";
         end
         for (int s = DEPTH - 2; s > 0; s--) begin
            h_v[s] = h_v[s-1]; h_t[s] = h_t[s-1]; h_p[s] = h_p[s-1];
         end
         h_v[0] = en_now; h_t[0] = 2'(e_ptr); h_p[0] = ipc;
         e_ptr = (e_ptr + 1) % N;

         @(negedge clk);
      end

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule